// File: doc/BRIEF.md
# Four-Input Pipelined Rank Sorter

This block takes four unsigned words at once and presents them again in ascending order. Sorting is not done with a chain of compare-and-swap steps. All six input pairs are compared side by side. From those comparison bits, each input's rank (its final output position) is worked out. Every output position then picks its word from the four stored inputs through a 4:1 multiplexer.

The logic is cut into two pipeline stages of similar depth. The first stage computes the six comparison bits and registers them, together with a copy of all four inputs. The second stage has no register of its own. It turns the registered bits into one 2-bit select per output and drives the four multiplexers. A new input set can be applied on every clock. The sorted set appears one clock later, next to an output valid that is the input valid delayed by the same register.

Top module: `rank_sort4`

## Requirements
- R1: When `out_valid` is high, the outputs are in ascending order: `out0 <= out1 <= out2 <= out3`. `out0` holds the smallest value and `out3` the largest.
- R2: The four outputs are a permutation of the four inputs sampled at the previous clock edge. Every input value appears once for each time it was applied, and no other value appears.
- R3: The outputs reflect the inputs sampled at the immediately preceding rising edge, which is a latency of exactly one clock.
- R4: A different input set may be applied on every consecutive clock, and each set is sorted without loss or stall.
- R5: Outside reset, `out_valid` equals the `in_valid` sampled at the preceding rising edge.
- R6: A high `rst` at a rising edge forces `out_valid` low after that edge. Reset does not clear the data path, so the sorted data of the inputs sampled at that edge still appear.
- R7: When two or more inputs are equal, the outputs still form a full permutation. For example, four equal inputs give four outputs of that same value, and two equal pairs give each value twice.
- R8: The data path does not depend on `in_valid`. Inputs sampled while `in_valid` is low are still sorted onto the outputs one clock later, with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid bit |
| in_valid | input | 1 | Marks the input set as meaningful |
| in0 | input | DATA_W | Input word, index 0 |
| in1 | input | DATA_W | Input word, index 1 |
| in2 | input | DATA_W | Input word, index 2 |
| in3 | input | DATA_W | Input word, index 3 |
| out_valid | output | 1 | `in_valid` delayed one clock, cleared by reset |
| out0 | output | DATA_W | Smallest of the sorted set |
| out1 | output | DATA_W | Second smallest |
| out2 | output | DATA_W | Second largest |
| out3 | output | DATA_W | Largest of the sorted set |

## Verification
Two things can fall in the same clock: a reset that clears the valid bit, and a fresh input set entering the data register. The bench provokes this by raising `rst` in the middle of a stream of valid, changing sets. In those cycles it expects `out_valid` low and, at the same time, the correctly sorted data of the set sampled at that edge (R6). Separately, it mixes ties with new sets on every clock. Each result is judged against a sort of the applied words done in the bench.

// File: rtl/rank_sort_pkg.sv
package rank_sort_pkg;

  localparam int NUM   = 4;
  localparam int NPAIR = NUM * (NUM - 1) / 2;
  localparam int SEL_W = $clog2(NUM);

  typedef logic [SEL_W-1:0] sel_t;

  // Flat index of unordered pair (a, b), a < b, in row-major order.
  function automatic int pair_idx(input int a, input int b);
    int idx;
    idx = 0;
    for (int i = 0; i < NUM; i++) begin
      for (int j = i + 1; j < NUM; j++) begin
        if (i == a && j == b) return idx;
        idx++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/rs_compare_stage.sv
module rs_compare_stage
  import rank_sort_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [NUM-1:0][DATA_W-1:0]   din,
  output logic [NUM-1:0][DATA_W-1:0]   data_q,
  output logic [NPAIR-1:0]             cmp_q,
  output logic                         valid_q
);

  logic [NPAIR-1:0] cmp_d;

  // Bit set when the higher-index word is strictly smaller, so ties favour the lower index.
  for (genvar a = 0; a < NUM; a++) begin : g_row
    for (genvar b = a + 1; b < NUM; b++) begin : g_col
      assign cmp_d[pair_idx(a, b)] = din[b] < din[a];
    end
  end

  always_ff @(posedge clk) begin
    data_q <= din;
    cmp_q  <= cmp_d;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= in_valid;
  end

  // R5: valid follows input valid with one register of delay
  a_r5_valid_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (valid_q == $past(in_valid)));

  // R6: reset clears valid on the following cycle
  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> !valid_q);

endmodule

// File: rtl/rs_select_gen.sv
module rs_select_gen
  import rank_sort_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NPAIR-1:0]  cmp_q,
  output sel_t [NUM-1:0]    sel
);

  sel_t [NUM-1:0]          rank;
  logic [NUM-1:0][NUM-1:0] hit;   // hit[p][k]: input k lands on position p

  always_comb begin
    for (int k = 0; k < NUM; k++) begin
      int r;
      r = 0;
      for (int j = 0; j < NUM; j++) begin
        if (j < k && !cmp_q[pair_idx(j, k)]) r++;
        if (j > k &&  cmp_q[pair_idx(k, j)]) r++;
      end
      rank[k] = SEL_W'(r);
    end
  end

  always_comb begin
    for (int p = 0; p < NUM; p++) begin
      for (int k = 0; k < NUM; k++) begin
        hit[p][k] = (rank[k] == SEL_W'(p));
      end
    end
  end

  for (genvar p = 0; p < NUM; p++) begin : g_enc
    always_comb begin
      sel[p] = '0;
      for (int k = 0; k < NUM; k++) begin
        if (hit[p][k]) sel[p] = SEL_W'(k);
      end
    end

    // R2, R7: every output position is claimed by exactly one input
    a_r2_one_owner: assert property (@(posedge clk) disable iff (rst)
      $onehot(hit[p]));
  end

endmodule

// File: rtl/rs_out_mux.sv
module rs_out_mux
  import rank_sort_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NUM-1:0][DATA_W-1:0] data_q,
  input  sel_t [NUM-1:0]             sel,
  output logic [NUM-1:0][DATA_W-1:0] dout
);

  for (genvar p = 0; p < NUM; p++) begin : g_mux
    always_comb begin
      dout[p] = data_q[0];
      for (int k = 1; k < NUM; k++) begin
        if (sel[p] == SEL_W'(k)) dout[p] = data_q[k];
      end
    end
  end

endmodule

// File: rtl/rank_sort4.sv
module rank_sort4
  import rank_sort_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in0,
  input  logic [DATA_W-1:0] in1,
  input  logic [DATA_W-1:0] in2,
  input  logic [DATA_W-1:0] in3,
  output logic              out_valid,
  output logic [DATA_W-1:0] out0,
  output logic [DATA_W-1:0] out1,
  output logic [DATA_W-1:0] out2,
  output logic [DATA_W-1:0] out3
);

  logic [NUM-1:0][DATA_W-1:0] din;
  logic [NUM-1:0][DATA_W-1:0] data_q;
  logic [NUM-1:0][DATA_W-1:0] dout;
  logic [NPAIR-1:0]           cmp_q;
  sel_t [NUM-1:0]             sel;

  assign din = {in3, in2, in1, in0};

  rs_compare_stage #(.DATA_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .din      (din),
    .data_q   (data_q),
    .cmp_q    (cmp_q),
    .valid_q  (out_valid)
  );

  rs_select_gen u_sel (
    .clk   (clk),
    .rst   (rst),
    .cmp_q (cmp_q),
    .sel   (sel)
  );

  rs_out_mux #(.DATA_W(DATA_W)) u_mux (
    .data_q (data_q),
    .sel    (sel),
    .dout   (dout)
  );

  assign out0 = dout[0];
  assign out1 = dout[1];
  assign out2 = dout[2];
  assign out3 = dout[3];

  // R1: ascending order at the outputs
  a_r1_ascending: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out0 <= out1 && out1 <= out2 && out2 <= out3));

  // R3: the smallest output bounds every input of the previous edge
  a_r3_min_bound: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) |=> (out0 <= $past(in0) && out0 <= $past(in1) &&
                         out0 <= $past(in2) && out0 <= $past(in3)));

  // R3: the largest output bounds every input of the previous edge
  a_r3_max_bound: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) |=> (out3 >= $past(in0) && out3 >= $past(in1) &&
                         out3 >= $past(in2) && out3 >= $past(in3)));

endmodule

// File: tb/rank_sort4_tb.sv
module rank_sort4_tb;

  localparam int DATA_W = 8;

  typedef struct {
    logic              vld;
    logic [DATA_W-1:0] s [4];
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in0 = '0, in1 = '0, in2 = '0, in3 = '0;
  logic              out_valid;
  logic [DATA_W-1:0] out0, out1, out2, out3;

  int   checks = 0;
  int   errors = 0;
  exp_t sb_q [$];
  logic done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  rank_sort4 #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in0(in0), .in1(in1), .in2(in2), .in3(in3),
    .out_valid(out_valid),
    .out0(out0), .out1(out1), .out2(out2), .out3(out3)
  );

  // Driver: applies one set at a falling edge and queues the expected result.
  task automatic drive(input logic v, input logic r,
                       input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                       input logic [DATA_W-1:0] c, input logic [DATA_W-1:0] d);
    exp_t e;
    logic [DATA_W-1:0] t;
    @(negedge clk);
    rst = r; in_valid = v;
    in0 = a; in1 = b; in2 = c; in3 = d;
    e.s[0] = a; e.s[1] = b; e.s[2] = c; e.s[3] = d;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3 - i; j++)
        if (e.s[j] > e.s[j+1]) begin
          t = e.s[j]; e.s[j] = e.s[j+1]; e.s[j+1] = t;
        end
    e.vld = r ? 1'b0 : v;
    sb_q.push_back(e);
  endtask

  // Monitor: one pop per rising edge, sampled 1 ns after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic [DATA_W-1:0] got [4];
        e = sb_q.pop_front();
        got[0] = out0; got[1] = out1; got[2] = out2; got[3] = out3;
        checks++;
        if (out_valid !== e.vld) begin
          errors++;
          $display("FAIL R5/R6 out_valid got %0b expected %0b", out_valid, e.vld);
        end
        for (int p = 0; p < 4; p++) begin
          checks++;
          if (got[p] !== e.s[p]) begin
            errors++;
            $display("FAIL R1/R2/R3 out%0d got %0d expected %0d", p, got[p], e.s[p]);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R6 out_valid in reset got %0b expected 0", out_valid);
    end

    // R3: latency with distinct values
    drive(1, 0, 8'd40, 8'd10, 8'd30, 8'd20);
    // R7: all equal, equal pairs, triple tie
    drive(1, 0, 8'd77, 8'd77, 8'd77, 8'd77);
    drive(1, 0, 8'd5,  8'd9,  8'd5,  8'd9);
    drive(1, 0, 8'd200, 8'd3, 8'd200, 8'd200);
    // R1: already ascending and reverse order, extremes
    drive(1, 0, 8'd1,  8'd2,  8'd3,  8'd4);
    drive(1, 0, 8'd255, 8'd128, 8'd1, 8'd0);
    drive(1, 0, 8'd0,  8'd255, 8'd0, 8'd255);
    // R8: in_valid low, data still sorted
    drive(0, 0, 8'd9,  8'd8,  8'd7,  8'd6);
    drive(1, 0, 8'd60, 8'd50, 8'd70, 8'd40);
    // R6: reset mid-stream while data keeps moving
    drive(1, 1, 8'd12, 8'd11, 8'd14, 8'd13);
    drive(1, 1, 8'd100, 8'd90, 8'd90, 8'd80);
    drive(1, 0, 8'd33, 8'd22, 8'd44, 8'd11);
    // R4: back-to-back random sets with mixed valid
    for (int n = 0; n < 200; n++) begin
      logic [DATA_W-1:0] r0, r1, r2, r3;
      r0 = DATA_W'($urandom); r1 = DATA_W'($urandom);
      r2 = (n % 5 == 0) ? r0 : DATA_W'($urandom);
      r3 = DATA_W'($urandom % 4);
      drive(1'($urandom % 4 != 0), 0, r0, r1, r2, r3);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R4 results left unchecked got %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule